// File: doc/BRIEF.md
# Ones-Complement Tick Wait Counter

The block lets one requester pause until a number of slow time ticks have gone by. The requester offers an 18-bit ones-complement word on a valid/ready request port. A word that is positive, plus zero or minus zero needs no wait: the unit accepts it, pulses `done` on the next cycle and reports the word unchanged. A negative word starts a wait. On each slow tick the running value is advanced by one ones-complement addition. When the value reaches zero the unit reports plus zero, drops `busy` and pulses `done`.

The slow tick is either taken from the `ext_tick` pin or made inside the block by a fractional prescaler. The prescaler divides the system clock so that the long-run average is exactly 1760 ticks per minute (about 29.33 Hz), whatever the clock frequency. Back-pressure rule: `req_ready` is high whenever no wait is in progress. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_value` is sampled in that cycle. While a wait runs `req_ready` stays low, and the requester must hold or withdraw its request. The result side has no back-pressure: `done` is a one-cycle pulse, and `value_out` holds its value until the next accepted request.

Top module: `oc_tick_wait`

## Requirements
- R1: After reset `busy` and `done` are 0, `value_out` is plus zero, and `req_ready` is 1. `req_ready` is 1 exactly when `busy` is 0. A request is taken in a cycle with `req_valid`=1 and `req_ready`=1, and `value_out` equals the sampled `req_value` one cycle later.
- R2: A taken word with bit 17 equal to 0 completes at once. One cycle after acceptance `done`=1, `busy`=0 and `value_out` equals the word. Back-to-back requests of this kind are taken on consecutive cycles.
- R3: A taken word of all ones (minus zero) also completes at once, and `value_out` stays all ones.
- R4: A taken word with bit 17 = 1 that is not all ones makes `busy`=1 one cycle after acceptance, with `done`=0 and `value_out` equal to the word.
- R5: While busy, each cycle with the tick high adds one to the running value with end-around carry (carry out of bit 17 added into bit 0). The result shows on `value_out` one cycle later. In cycles without a tick `value_out` is unchanged.
- R6: When an increment yields zero (all zeros or all ones), `value_out` becomes plus zero, `busy` falls and `done` is 1 in that same cycle. A word whose bitwise complement is n therefore completes after exactly n ticks.
- R7: A request presented while busy is not taken. `req_ready` is 0, and the running value and the wait are unaffected.
- R8: A tick in the same cycle as an acceptance does not advance the newly loaded value.
- R9: `done` lasts one cycle per completion. After completion `value_out` holds until the next accepted request.
- R10: With the internal source selected (`USE_EXT_TICK`=0), `tick_out` carries one-cycle pulses. Exactly `TICKS_PER_MIN` pulses occur in every window of 60·`CLK_HZ` cycles, and successive pulses are spaced by the floor or the ceiling of the mean period.
- R11: With the external source selected (`USE_EXT_TICK`=1), `tick_out` follows `ext_tick` and `ext_tick` is the tick that advances the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | External slow tick, one clock wide per tick |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_value | input | 18 | Ones-complement word of the request |
| busy | output | 1 | Wait in progress |
| done | output | 1 | One-cycle completion pulse |
| value_out | output | 18 | Running or final value |
| tick_out | output | 1 | Tick driving the counter |

## Verification
The bench builds two copies of the block. The first uses `USE_EXT_TICK`=1, so the bench places every tick on a chosen cycle. This gives direct access to the step-by-step count, ticks that coincide with acceptance, gaps without ticks, and requests made while busy. The second uses the internal prescaler with `CLK_HZ`=1000. At that setting one full minute is only 60000 cycles, so the exact count of 1760 ticks per minute and the alternating 34/35-cycle spacing can be checked within one run.

// File: rtl/oc_wait_pkg.sv
package oc_wait_pkg;
  localparam int unsigned OC_WORD_W_DEF = 18;
  localparam longint unsigned OC_TICKS_PER_MIN_DEF = 1760;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_COUNT = 1'b1
  } oc_state_e;
endpackage

// File: rtl/oc_incrementer.sv
module oc_incrementer #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] val_in,
  output logic [W-1:0] val_next,
  output logic         next_is_zero
);
  logic [W:0]   raw_sum;
  logic [W-1:0] wrapped;

  // add one, then fold the carry out of the top bit back into bit 0
  always_comb begin
    raw_sum  = {1'b0, val_in} + {{W{1'b0}}, 1'b1};
    wrapped  = raw_sum[W-1:0] + {{(W-1){1'b0}}, raw_sum[W]};
    val_next = wrapped;
  end

  // both encodings of zero end a wait
  assign next_is_zero = (wrapped == '0) || (&wrapped);
endmodule

// File: rtl/oc_prescaler.sv
module oc_prescaler #(
  parameter longint unsigned CLK_HZ        = 100_000_000,
  parameter longint unsigned TICKS_PER_MIN = 1760
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam longint unsigned DEN   = 60 * CLK_HZ;
  localparam longint unsigned NUM   = TICKS_PER_MIN;
  localparam int              ACC_W = $clog2(DEN + NUM + 1);
  localparam logic [ACC_W-1:0] DEN_W = ACC_W'(DEN);
  localparam logic [ACC_W-1:0] NUM_W = ACC_W'(NUM);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_w;
  logic             tick_q;

  assign sum_w = acc_q + NUM_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (sum_w >= DEN_W) begin
      acc_q  <= sum_w - DEN_W;
      tick_q <= 1'b1;
    end else begin
      acc_q  <= sum_w;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < DEN_W) else $error("accumulator out of range"); // R10

  generate
    if (2 * NUM <= DEN) begin : g_sparse
      AST_TICK_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q) else $error("tick wider than one cycle"); // R10
    end
  endgenerate
endmodule

// File: rtl/oc_wait_core.sv
module oc_wait_core
  import oc_wait_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_value,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] value_out
);
  oc_state_e    state_q;
  logic [W-1:0] val_q;
  logic         done_q;
  logic         accept;
  logic         needs_wait;
  logic [W-1:0] stepped;
  logic         step_zero;

  oc_incrementer #(.W(W)) u_inc (
    .val_in       (val_q),
    .val_next     (stepped),
    .next_is_zero (step_zero)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  // negative and not minus zero
  assign needs_wait = req_value[W-1] && !(&req_value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      val_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            val_q <= req_value;
            if (needs_wait) state_q <= ST_COUNT;
            else            done_q  <= 1'b1;
          end
        end
        ST_COUNT: begin
          if (tick) begin
            if (step_zero) begin
              val_q   <= '0;
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              val_q <= stepped;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q == ST_COUNT);
  assign done      = done_q;
  assign value_out = val_q;

  AST_LOAD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> value_out == $past(req_value)) else $error("load"); // R8
  AST_RELEASE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!value_out[W-1] || (&value_out))) else $error("release sign"); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> busy && $stable(value_out)) else $error("moved w/o tick"); // R5
  AST_FALL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done && (value_out == '0)) else $error("bad end"); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !req_valid |=> !busy && !done && $stable(value_out)) else $error("idle drift"); // R9
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid && !tick |=> busy && $stable(value_out)) else $error("busy req"); // R7
endmodule

// File: rtl/oc_tick_wait.sv
module oc_tick_wait
  import oc_wait_pkg::*;
#(
  parameter int unsigned     W             = OC_WORD_W_DEF,
  parameter bit              USE_EXT_TICK  = 1'b0,
  parameter longint unsigned CLK_HZ        = 100_000_000,
  parameter longint unsigned TICKS_PER_MIN = OC_TICKS_PER_MIN_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_tick,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_value,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] value_out,
  output logic         tick_out
);
  logic pre_tick;
  logic tick_w;

  oc_prescaler #(
    .CLK_HZ        (CLK_HZ),
    .TICKS_PER_MIN (TICKS_PER_MIN)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (pre_tick)
  );

  assign tick_w   = USE_EXT_TICK ? ext_tick : pre_tick;
  assign tick_out = tick_w;

  oc_wait_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_value (req_value),
    .busy      (busy),
    .done      (done),
    .value_out (value_out)
  );
endmodule

// File: tb/oc_tick_wait_tb_top.sv
`timescale 1ns/1ps
module oc_tick_wait_tb_top;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         ext_tick = 1'b0;
  logic         req_valid = 1'b0;
  logic [W-1:0] req_value = '0;
  logic         req_ready, busy, done, tick_out;
  logic [W-1:0] value_out;

  logic         p_ready, p_busy, p_done, p_tick;
  logic [W-1:0] p_value;

  int checks = 0;
  int fails  = 0;

  oc_tick_wait #(.W(W), .USE_EXT_TICK(1'b1), .CLK_HZ(1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_value(req_value),
    .busy(busy), .done(done), .value_out(value_out), .tick_out(tick_out)
  );

  oc_tick_wait #(.W(W), .USE_EXT_TICK(1'b0), .CLK_HZ(1000)) dut_ps_i (
    .clk(clk), .rst_n(rst_n), .ext_tick(1'b0),
    .req_valid(1'b0), .req_ready(p_ready), .req_value('0),
    .busy(p_busy), .done(p_done), .value_out(p_value), .tick_out(p_tick)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(value_out == '0, "R1 value after reset", value_out, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
  endtask

  task automatic t_immediate(input logic [W-1:0] v, input string tag);
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " ready idle"}, req_ready, 1);
    req_valid = 1'b1; req_value = v;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b1, {tag, " done pulse"}, done, 1);
    chk(busy == 1'b0, {tag, " no busy"}, busy, 0);
    chk(value_out == v, {tag, " value kept"}, value_out, v);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    chk(value_out == v, "R9 value holds", value_out, v);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_value = 18'h00007;
    @(negedge clk);
    chk(done && value_out == 18'h00007, "R2 first of pair", value_out, 7);
    chk(req_ready == 1'b1, "R1 ready after immediate", req_ready, 1);
    req_value = 18'h1FFFF;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && value_out == 18'h1FFFF, "R2 second of pair", value_out, 18'h1FFFF);
    @(negedge clk);
  endtask

  task automatic tick_once();
    @(negedge clk);
    ext_tick = 1'b1;
    #1;
    chk(tick_out == 1'b1, "R11 tick_out follows ext_tick", tick_out, 1);
    @(negedge clk);
    ext_tick = 1'b0;
  endtask

  task automatic t_counted(input int n);
    logic [W-1:0] v;
    v = ~W'(n);
    @(negedge clk);
    req_valid = 1'b1; req_value = v;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R4 busy after negative", busy, 1);
    chk(done == 1'b0, "R4 no done at start", done, 0);
    chk(value_out == v, "R4 value loaded", value_out, v);
    chk(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
    for (int k = 1; k <= n; k++) begin
      tick_once();
      if (k < n) begin
        chk(busy && !done && value_out == ~W'(n - k), "R5 step value", value_out, ~W'(n - k));
      end else begin
        chk(!busy && done && value_out == '0, "R6 completes at zero", value_out, 0);
      end
      if (k == 1 && n > 1) begin
        repeat (3) @(negedge clk);
        chk(value_out == ~W'(n - 1) && busy, "R5 no change without tick", value_out, ~W'(n - 1));
      end
    end
    @(negedge clk);
    chk(!done && value_out == '0, "R9 after counted completion", value_out, 0);
  endtask

  task automatic t_busy_ignore();
    logic [W-1:0] v;
    v = ~W'(3);
    @(negedge clk);
    req_valid = 1'b1; req_value = v;
    @(negedge clk);
    req_value = 18'h00005;
    @(negedge clk);
    @(negedge clk);
    chk(req_ready == 1'b0, "R7 ready low", req_ready, 0);
    chk(busy && !done && value_out == v, "R7 busy request ignored", value_out, v);
    req_valid = 1'b0;
    tick_once();
    chk(value_out == ~W'(2), "R7 wait continues", value_out, ~W'(2));
    tick_once();
    tick_once();
    chk(done && value_out == '0, "R7 wait ends normally", value_out, 0);
    @(negedge clk);
  endtask

  task automatic t_tick_on_accept();
    logic [W-1:0] v;
    v = ~W'(2);
    @(negedge clk);
    req_valid = 1'b1; req_value = v; ext_tick = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; ext_tick = 1'b0;
    chk(value_out == v && busy, "R8 tick at accept not counted", value_out, v);
    tick_once();
    chk(busy && value_out == ~W'(1), "R8 first real tick", value_out, ~W'(1));
    tick_once();
    chk(done && !busy, "R8 ends after two ticks", busy, 0);
    @(negedge clk);
  endtask

  task automatic t_prescaler();
    int count;
    int gap;
    int gmin;
    int gmax;
    bit seen;
    count = 0; gap = 0; gmin = 1 << 30; gmax = 0; seen = 1'b0;
    for (int c = 0; c < 60000; c++) begin
      @(negedge clk);
      gap++;
      if (p_tick) begin
        count++;
        if (seen) begin
          if (gap < gmin) gmin = gap;
          if (gap > gmax) gmax = gap;
        end
        seen = 1'b1;
        gap = 0;
      end
    end
    chk(count == 1760, "R10 ticks per minute", count, 1760);
    chk(gmin == 34, "R10 shortest gap", gmin, 34);
    chk(gmax == 35, "R10 longest gap", gmax, 35);
    chk(!p_busy && !p_done && p_ready, "R10 idle prescaled unit", p_busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate(18'h00000, "R2 plus zero");
    t_immediate(18'h1FFFF, "R2 max positive");
    t_immediate(18'h12345, "R2 positive");
    t_immediate(18'h3FFFF, "R3 minus zero");
    t_back_to_back();
    t_counted(1);
    t_counted(5);
    t_counted(40);
    t_busy_ignore();
    t_tick_on_accept();
    t_prescaler();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule